// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block keeps exception bookkeeping for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) so that faults are reported in program order, even when a younger instruction faults earlier in time than an older one. Each stage may raise fault strobes for the instruction it currently holds. These strobes are merged into a per-instruction status vector that travels with that instruction. While any bit of the vector is set, the stage holding the instruction raises a write-kill line so the datapath can suppress its architectural effects.

A fault is acted on only when its instruction reaches write-back. In that cycle the block raises `exc_taken_o` and `flush_o`. It presents the handler entry address on `redirect_pc_o` and clears every stage, so the faulting instruction and all younger ones become bubbles and can be restarted. At the same clock edge it saves the faulting PC and a 4-bit cause code. A global stall freezes the tracked slots. A flush overrides a stall.

Top module: `exc_tracker`

## Requirements
- R1: While reset is asserted and right after it, `kill_o`, `exc_taken_o` and `flush_o` are 0 when no valid instruction carries a fault, and `epc_o` and `cause_o` are 0.
- R2: Without stall, an instruction presented in fetch in cycle t occupies decode, execute, memory and write-back in cycles t+1 to t+4, so a fault it carries is taken in cycle t+4.
- R3: `kill_o[s]` (index 0 = fetch through 4 = write-back) is high in any cycle where stage s holds a valid instruction whose status vector, including strobes raised by stage s in that cycle, is non-zero.
- R4: `exc_taken_o` is high only in a cycle where write-back holds a valid instruction with a non-zero vector. From the following cycle, `epc_o` shows that instruction's PC and `cause_o` shows its code. Both hold until the next taken exception.
- R5: The cause codes are 1 = fetch page fault (`if_exc_i[0]`), 2 = misaligned fetch (`if_exc_i[1]`), 3 = fetch protection (`if_exc_i[2]`), 4 = illegal opcode, 5 = arithmetic, 6 = data page fault (`mem_exc_i[0]`), 7 = misaligned data (`mem_exc_i[1]`), 8 = data protection (`mem_exc_i[2]`). When one instruction carries several flags, the lowest code wins.
- R6: If an older instruction faults in memory while a younger one has already faulted in fetch, only the older one is reported, and the younger one is never taken.
- R7: In a taken cycle, `kill_o` is high for every stage holding a valid instruction. In the next cycle every stage is empty and no further exception is taken. This also applies when `stall_i` is high.
- R8: While `stall_i` is high and no flush occurs, the tracked instructions stay in place with their vectors unchanged. A stage's strobes are merged into the vector only at the edge where the instruction leaves that stage.
- R9: Strobes raised by a stage that holds no valid instruction have no effect.
- R10: While `flush_o` is high, `redirect_pc_o` equals the `HANDLER_PC` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freeze all tracked stages |
| if_valid_i | input | 1 | Fetch stage holds a valid instruction |
| if_pc_i | input | PC_W | PC of the instruction in fetch |
| if_exc_i | input | 3 | Fetch strobes: page fault, misaligned, protection |
| id_exc_i | input | 1 | Decode strobe: illegal opcode |
| ex_exc_i | input | 1 | Execute strobe: arithmetic fault |
| mem_exc_i | input | 3 | Memory strobes: page fault, misaligned, protection |
| kill_o | output | 5 | Per-stage write suppression, index 0 = fetch |
| exc_taken_o | output | 1 | Exception taken from write-back this cycle |
| flush_o | output | 1 | Squash all stages at the next edge |
| epc_o | output | PC_W | Saved PC of the last taken exception |
| cause_o | output | 4 | Saved cause code of the last taken exception |
| redirect_pc_o | output | PC_W | Handler fetch address while flushing |

## Verification
The hardest case to reach is an inversion of time and program order, where a younger instruction has already picked up a fetch fault while the older one ahead of it faults later in the memory stage. The stimulus table builds this by injecting a fetch fault on the second of two back-to-back instructions, then a data fault on the first one two cycles later. It then checks that only the older PC and cause are reported and that the younger fault never surfaces after the flush. A stall held on a faulting instruction in write-back is driven separately to show that the flush beats the stall.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam int NUM_STAGES = 5;
   localparam int VEC_W      = 8;
   localparam int CAUSE_W    = 4;
   localparam int IF_FLAGS   = 3;
   localparam int MEM_FLAGS  = 3;

   typedef enum logic [2:0] {
      STG_IF  = 3'd0,
      STG_ID  = 3'd1,
      STG_EX  = 3'd2,
      STG_MEM = 3'd3,
      STG_WB  = 3'd4
   } stage_e;

   // bit i of the status vector reports cause code i+1; lower index is earlier stage
   function automatic logic [VEC_W-1:0] stage_mask(input int s);
      case (s)
         0:       return 8'b0000_0111;
         1:       return 8'b0000_1000;
         2:       return 8'b0001_0000;
         3:       return 8'b1110_0000;
         default: return 8'b0000_0000;
      endcase
   endfunction
endpackage

// File: rtl/exc_stage_reg.sv
module exc_stage_reg #(
   parameter int PC_W  = 32,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_i,
   input  logic             clear_i,
   input  logic             valid_d,
   input  logic [PC_W-1:0]  pc_d,
   input  logic [VEC_W-1:0] vec_d,
   output logic             valid_q,
   output logic [PC_W-1:0]  pc_q,
   output logic [VEC_W-1:0] vec_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pc_q    <= '0;
         vec_q   <= '0;
      end else if (clear_i) begin
         valid_q <= 1'b0;
         pc_q    <= '0;
         vec_q   <= '0;
      end else if (!hold_i) begin
         valid_q <= valid_d;
         pc_q    <= pc_d;
         vec_q   <= valid_d ? vec_d : '0;
      end
   end
endmodule

// File: rtl/exc_cause_enc.sv
module exc_cause_enc #(
   parameter int VEC_W   = 8,
   parameter int CAUSE_W = 4
) (
   input  logic [VEC_W-1:0]   vec_i,
   output logic [CAUSE_W-1:0] cause_o
);
   if (VEC_W >= (1 << CAUSE_W)) begin : g_bad_width
      $error("cause field too narrow for status vector");
   end

   always_comb begin
      cause_o = '0;
      for (int i = VEC_W - 1; i >= 0; i--) begin
         if (vec_i[i]) cause_o = CAUSE_W'(i + 1);
      end
   end
endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
   import exc_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = PC_W'('h180)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stall_i,
   input  logic                  if_valid_i,
   input  logic [PC_W-1:0]       if_pc_i,
   input  logic [IF_FLAGS-1:0]   if_exc_i,
   input  logic                  id_exc_i,
   input  logic                  ex_exc_i,
   input  logic [MEM_FLAGS-1:0]  mem_exc_i,
   output logic [NUM_STAGES-1:0] kill_o,
   output logic                  exc_taken_o,
   output logic                  flush_o,
   output logic [PC_W-1:0]       epc_o,
   output logic [CAUSE_W-1:0]    cause_o,
   output logic [PC_W-1:0]       redirect_pc_o
);
   localparam int WB = NUM_STAGES - 1;

   if (PC_W < 8) begin : g_bad_pc
      $error("PC_W must be at least 8");
   end
   if (HANDLER_PC[1:0] != 2'b00) begin : g_bad_handler
      $error("HANDLER_PC must be word aligned");
   end

   logic [VEC_W-1:0]      strobes;
   logic [NUM_STAGES-1:0] st_valid;
   logic [PC_W-1:0]       st_pc  [NUM_STAGES];
   logic [VEC_W-1:0]      st_vec [NUM_STAGES];
   logic [VEC_W-1:0]      st_mrg [NUM_STAGES];
   logic [CAUSE_W-1:0]    wb_cause;
   logic                  taken;

   assign strobes     = {mem_exc_i, ex_exc_i, id_exc_i, if_exc_i};
   assign st_valid[0] = if_valid_i;
   assign st_pc[0]    = if_pc_i;
   assign st_vec[0]   = '0;

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      assign st_mrg[s] = st_vec[s] | (st_valid[s] ? (strobes & stage_mask(s)) : '0);
      assign kill_o[s] = st_valid[s] & ((|st_mrg[s]) | taken);
      if (s > 0) begin : g_slot
         exc_stage_reg #(.PC_W(PC_W), .VEC_W(VEC_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold_i (stall_i),
            .clear_i(taken),
            .valid_d(st_valid[s-1]),
            .pc_d   (st_pc[s-1]),
            .vec_d  (st_mrg[s-1]),
            .valid_q(st_valid[s]),
            .pc_q   (st_pc[s]),
            .vec_q  (st_vec[s])
         );
      end
   end

   assign taken = st_valid[WB] & (|st_mrg[WB]);

   exc_cause_enc #(.VEC_W(VEC_W), .CAUSE_W(CAUSE_W)) u_enc (
      .vec_i  (st_mrg[WB]),
      .cause_o(wb_cause)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epc_o   <= '0;
         cause_o <= '0;
      end else if (taken) begin
         epc_o   <= st_pc[WB];
         cause_o <= wb_cause;
      end
   end

   assign exc_taken_o   = taken;
   assign flush_o       = taken;
   assign redirect_pc_o = taken ? HANDLER_PC : '0;
endmodule

// File: rtl/exc_tracker_chk.sv
module exc_tracker_chk #(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = PC_W'('h180)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            stall_i,
   input logic            if_valid_i,
   input logic [4:0]      kill_o,
   input logic            exc_taken_o,
   input logic            flush_o,
   input logic [PC_W-1:0] epc_o,
   input logic [3:0]      cause_o,
   input logic [PC_W-1:0] redirect_pc_o,
   input logic            id_valid,
   input logic [PC_W-1:0] id_pc,
   input logic [7:0]      id_vec,
   input logic            ex_valid,
   input logic [PC_W-1:0] wb_pc
);
   assert_no_retake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken_o |=> !exc_taken_o);

   assert_epc_saved_R4: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken_o |=> (epc_o == $past(wb_pc)));

   assert_cause_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken_o |=> (cause_o != 4'd0 && cause_o <= 4'd8));

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i && !flush_o) |=> ($stable(id_valid) && $stable(id_pc) && $stable(id_vec)));

   assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_i && !flush_o) |=> (ex_valid == $past(id_valid)));

   assert_if_kill_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      kill_o[0] |-> if_valid_i);

   assert_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> (redirect_pc_o == HANDLER_PC));

   assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> (!id_valid && !ex_valid));
endmodule

bind exc_tracker exc_tracker_chk #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stall_i      (stall_i),
   .if_valid_i   (if_valid_i),
   .kill_o       (kill_o),
   .exc_taken_o  (exc_taken_o),
   .flush_o      (flush_o),
   .epc_o        (epc_o),
   .cause_o      (cause_o),
   .redirect_pc_o(redirect_pc_o),
   .id_valid     (st_valid[1]),
   .id_pc        (st_pc[1]),
   .id_vec       (st_vec[1]),
   .ex_valid     (st_valid[2]),
   .wb_pc        (st_pc[4])
);

// File: tb/exc_tracker_tb.sv
module exc_tracker_tb;
   localparam int PC_W = 32;
   localparam logic [PC_W-1:0] HPC = 32'h180;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stall_i = 1'b0, if_valid_i = 1'b0, id_exc_i = 1'b0, ex_exc_i = 1'b0;
   logic [PC_W-1:0] if_pc_i = '0;
   logic [2:0] if_exc_i = '0, mem_exc_i = '0;
   logic [4:0] kill_o;
   logic exc_taken_o, flush_o;
   logic [PC_W-1:0] epc_o, redirect_pc_o;
   logic [3:0] cause_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   exc_tracker #(.PC_W(PC_W), .HANDLER_PC(HPC)) u_dut (
      .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .if_valid_i(if_valid_i),
      .if_pc_i(if_pc_i), .if_exc_i(if_exc_i), .id_exc_i(id_exc_i),
      .ex_exc_i(ex_exc_i), .mem_exc_i(mem_exc_i), .kill_o(kill_o),
      .exc_taken_o(exc_taken_o), .flush_o(flush_o), .epc_o(epc_o),
      .cause_o(cause_o), .redirect_pc_o(redirect_pc_o)
   );

   typedef struct packed {
      logic       stall;
      logic       ifv;
      logic [7:0] pc;
      logic [2:0] ifx;
      logic       idx;
      logic       exx;
      logic [2:0] memx;
      logic       taken;
      logic [4:0] kill;
      logic [3:0] cause;
      logic [7:0] epc;
   } row_t;

   // columns: stall ifv pc ifx idx exx memx | taken kill cause epc
   localparam row_t TBL [32] = '{
      // R2 arithmetic fault in EX on 0x10, taken four cycles after fetch
      row_t'{1'b0,1'b1,8'h10,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd0,8'h00},
      row_t'{1'b0,1'b1,8'h14,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd0,8'h00},
      row_t'{1'b0,1'b1,8'h18,3'b000,1'b0,1'b1,3'b000, 1'b0,5'b00100,4'd0,8'h00},
      row_t'{1'b0,1'b1,8'h1C,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b01000,4'd0,8'h00},
      row_t'{1'b0,1'b1,8'h20,3'b000,1'b0,1'b0,3'b000, 1'b1,5'b11111,4'd0,8'h00},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd5,8'h10},
      // R6 younger 0x44 faults in fetch, older 0x40 faults later in MEM
      row_t'{1'b0,1'b1,8'h40,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd5,8'h10},
      row_t'{1'b0,1'b1,8'h44,3'b001,1'b0,1'b0,3'b000, 1'b0,5'b00001,4'd5,8'h10},
      row_t'{1'b0,1'b1,8'h48,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00010,4'd5,8'h10},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b001, 1'b0,5'b01100,4'd5,8'h10},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b1,5'b11100,4'd5,8'h10},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd6,8'h40},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd6,8'h40},
      // R5 one instruction collects flags in every stage; misaligned fetch wins
      row_t'{1'b0,1'b1,8'h80,3'b110,1'b0,1'b0,3'b000, 1'b0,5'b00001,4'd6,8'h40},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b1,1'b0,3'b000, 1'b0,5'b00010,4'd6,8'h40},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b1,3'b000, 1'b0,5'b00100,4'd6,8'h40},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b100, 1'b0,5'b01000,4'd6,8'h40},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b1,5'b10000,4'd6,8'h40},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd2,8'h80},
      // R8 stall holds 0xA0 in decode; illegal opcode merged when it leaves
      row_t'{1'b0,1'b1,8'hA0,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd2,8'h80},
      row_t'{1'b1,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd2,8'h80},
      row_t'{1'b1,1'b0,8'h00,3'b000,1'b1,1'b0,3'b000, 1'b0,5'b00010,4'd2,8'h80},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b1,1'b0,3'b000, 1'b0,5'b00010,4'd2,8'h80},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00100,4'd2,8'h80},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b01000,4'd2,8'h80},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b1,5'b10000,4'd2,8'h80},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd4,8'hA0},
      // R9 strobes with an empty pipeline do nothing
      row_t'{1'b0,1'b0,8'h00,3'b111,1'b1,1'b1,3'b111, 1'b0,5'b00000,4'd4,8'hA0},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd4,8'hA0},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd4,8'hA0},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd4,8'hA0},
      row_t'{1'b0,1'b0,8'h00,3'b000,1'b0,1'b0,3'b000, 1'b0,5'b00000,4'd4,8'hA0}
   };

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic drive(input logic st, input logic v, input logic [7:0] pc,
                        input logic [2:0] ix, input logic dx, input logic ex,
                        input logic [2:0] mx);
      stall_i = st; if_valid_i = v; if_pc_i = {24'h0, pc};
      if_exc_i = ix; id_exc_i = dx; ex_exc_i = ex; mem_exc_i = mx;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset kill", 32'(kill_o), 32'h0);
      chk("R1 reset taken", 32'(exc_taken_o), 32'h0);
      chk("R1 reset epc", epc_o, 32'h0);
      chk("R1 reset cause", 32'(cause_o), 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         drive(TBL[i].stall, TBL[i].ifv, TBL[i].pc, TBL[i].ifx, TBL[i].idx,
               TBL[i].exx, TBL[i].memx);
         #1;
         chk($sformatf("R3 kill row %0d", i), 32'(kill_o), 32'(TBL[i].kill));
         chk($sformatf("R4 taken row %0d", i), 32'(exc_taken_o), 32'(TBL[i].taken));
         chk($sformatf("R7 flush row %0d", i), 32'(flush_o), 32'(TBL[i].taken));
         chk($sformatf("R5 cause row %0d", i), 32'(cause_o), 32'(TBL[i].cause));
         chk($sformatf("R4 epc row %0d", i), epc_o, 32'(TBL[i].epc));
      end

      // R7 flush beats stall: data misaligned on 0xC0, stall held in write-back
      @(negedge clk); drive(1'b0, 1'b1, 8'hC0, 3'b000, 1'b0, 1'b0, 3'b000);
      @(negedge clk); drive(1'b0, 1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 3'b000);
      @(negedge clk);
      @(negedge clk); drive(1'b0, 1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 3'b010);
      @(negedge clk); drive(1'b1, 1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 3'b000);
      #1;
      chk("R7 taken under stall", 32'(exc_taken_o), 32'h1);
      chk("R7 kill under stall", 32'(kill_o), 32'h10);
      chk("R10 redirect", redirect_pc_o, HPC);
      @(negedge clk); #1;
      chk("R7 no retake under stall", 32'(exc_taken_o), 32'h0);
      chk("R5 cause misaligned data", 32'(cause_o), 32'h7);
      chk("R4 epc after stall take", epc_o, 32'hC0);
      chk("R10 redirect idle", 32'(flush_o), 32'h0);

      done = 1;
      finish_run();
   end
endmodule